// File: doc/BRIEF.md
# Hard and Soft Reset Sequencer

This block is the reset controller of a processor subsystem. It gathers requests for a destructive (hard) reset from several places: a two-button chord on the board, a loss of lock on either of two PLLs, a core check-stop (only when its reset enable is set), a bus-monitor timeout, a software watchdog expiry, a JTAG-forced request, and another agent that pulls the shared hard-reset line low. Any one of these starts a fixed-length hard-reset phase. A soft-reset phase of the same length always follows it.

Both reset lines are modelled as open-drain outputs. Each has a data pin that is tied low and an output-enable that turns the pull-down on. The block never drives either line high, so other agents can share the wire. When the hard phase ends, the block latches a configuration byte. The byte is either a built-in default or the upper byte of the external data bus, and a strap input chooses between them. A status register keeps the set of sources that started the most recent hard reset. Only a power-on reset clears it.

Top module: `rst_sequencer`

## Requirements
- R1: Pressing both `btn_soft` and `btn_abort` in the same cycle starts a hard reset. Either button pressed alone leaves both output-enables low.
- R2: A low level on either `pll_lock_a` or `pll_lock_b`, with the block idle, starts a hard reset.
- R3: A high `chkstop` starts a hard reset only when `chkstop_rst_en` is 1. With the enable at 0, the block stays idle.
- R4: A pulse on `busmon_tmo`, `wdog_exp` or `jtag_hreset` each starts a hard reset.
- R5: While the block is idle, a low level on `hreset_line_i` driven by another agent starts a hard reset. While a sequence runs, the line level is ignored.
- R6: During the hard phase, `hreset_oe` stays high for exactly PHASE_CYCLES (512) consecutive cycles. `hreset_n_o` and `sreset_n_o` are low at all times.
- R7: Every hard phase is followed at once by a soft phase of PHASE_CYCLES cycles. During this phase `sreset_oe` is high and `hreset_oe` is low. `sreset_oe` is also high through the whole hard phase.
- R8: A request that arrives during the hard phase is ignored and changes neither the phase length nor `hreset_cause`. A request that arrives during the soft phase starts a new hard phase.
- R9: When the hard phase ends, `cfg_word` takes CFG_DEFAULT (8'h5A) if `rstconf_n` is 1, or `ext_bus_hi` if `rstconf_n` is 0. It holds that value until the next hard phase ends.
- R10: When a hard phase starts, `hreset_cause` stores which sources were active. The bit map is: bit0 button chord, bit1 PLL unlock, bit2 enabled check-stop, bit3 bus monitor, bit4 watchdog, bit5 JTAG, bit6 external line. The value is kept after the sequence ends and is cleared only by `rst_n`.
- R11: While `rst_n` is low, both output-enables are low, `hreset_cause` is 0 and `cfg_word` equals CFG_DEFAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| btn_soft | input | 1 | Soft-reset button, debounced, high when pressed |
| btn_abort | input | 1 | Abort button, debounced, high when pressed |
| pll_lock_a | input | 1 | Core PLL lock indication, low when unlocked |
| pll_lock_b | input | 1 | Peripheral PLL lock indication, low when unlocked |
| chkstop | input | 1 | Core check-stop indication |
| chkstop_rst_en | input | 1 | Mode bit that allows check-stop to cause reset |
| busmon_tmo | input | 1 | Bus-monitor timeout |
| wdog_exp | input | 1 | Software watchdog expiry |
| jtag_hreset | input | 1 | Hard reset forced through the JTAG scan chain |
| hreset_line_i | input | 1 | Level read back from the shared hard-reset wire |
| rstconf_n | input | 1 | Configuration-source strap, low selects the external bus |
| ext_bus_hi | input | CFG_W | Upper byte of the external data bus |
| hreset_n_o | output | 1 | Hard-reset data pin, always low |
| hreset_oe | output | 1 | Hard-reset pull-down enable |
| sreset_n_o | output | 1 | Soft-reset data pin, always low |
| sreset_oe | output | 1 | Soft-reset pull-down enable |
| cfg_word | output | CFG_W | Configuration byte latched at the end of the hard phase |
| hreset_cause | output | 7 | Sources that started the last hard reset |

## Verification
The assertions check the invariants of the phase timing on every cycle. The hard enable never exceeds PHASE_CYCLES and always falls after exactly that count. The soft enable covers the whole hard phase and the hand-over to the soft phase. The button chord always starts a hard phase when no hard phase is running. The cause and configuration registers change only on their own phase edges. Other properties need whole scenarios, so only the bench scenarios can show them: the check-stop gating, masking the shared line while a sequence runs, a request ignored in the hard phase against one that restarts from the soft phase, and the exact cause bit map and configuration value after random mixes of sources and straps.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  // Request vector bit map; the cause register exposes this order.
  localparam int unsigned SRC_N       = 7;
  localparam int unsigned SRC_CHORD   = 0;
  localparam int unsigned SRC_PLL     = 1;
  localparam int unsigned SRC_CHKSTOP = 2;
  localparam int unsigned SRC_BUSMON  = 3;
  localparam int unsigned SRC_WDOG    = 4;
  localparam int unsigned SRC_JTAG    = 5;
  localparam int unsigned SRC_LINE    = 6;

  typedef logic [SRC_N-1:0] src_vec_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HARD = 2'd1,
    PH_SOFT = 2'd2
  } phase_e;
endpackage

// File: rtl/rst_src_collect.sv
module rst_src_collect
  import rst_seq_pkg::*;
(
  input  logic     btn_soft,
  input  logic     btn_abort,
  input  logic     pll_lock_a,
  input  logic     pll_lock_b,
  input  logic     chkstop,
  input  logic     chkstop_rst_en,
  input  logic     busmon_tmo,
  input  logic     wdog_exp,
  input  logic     jtag_hreset,
  input  logic     hreset_line_i,
  output src_vec_t raw_req
);
  always_comb begin
    raw_req              = '0;
    raw_req[SRC_CHORD]   = btn_soft & btn_abort;
    raw_req[SRC_PLL]     = ~pll_lock_a | ~pll_lock_b;
    raw_req[SRC_CHKSTOP] = chkstop & chkstop_rst_en;
    raw_req[SRC_BUSMON]  = busmon_tmo;
    raw_req[SRC_WDOG]    = wdog_exp;
    raw_req[SRC_JTAG]    = jtag_hreset;
    raw_req[SRC_LINE]    = ~hreset_line_i;
  end
endmodule

// File: rtl/rst_req_sync.sv
module rst_req_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rst_phase_fsm.sv
module rst_phase_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned PHASE_CYCLES = 512
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t req,
  output phase_e   phase,
  output logic     hard_start,
  output logic     hard_done,
  output src_vec_t req_eff
);
  localparam int unsigned CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             any_req, at_last;

  always_comb begin
    req_eff = req;
    if (phase_q != PH_IDLE) req_eff[SRC_LINE] = 1'b0;
    any_req    = |req_eff;
    at_last    = (cnt_q == CNT_LAST);
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    hard_start = 1'b0;
    hard_done  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (any_req) begin
          phase_d    = PH_HARD;
          cnt_d      = '0;
          cnt_en     = 1'b1;
          hard_start = 1'b1;
        end
      end
      PH_HARD: begin
        cnt_en = 1'b1;
        if (at_last) begin
          phase_d   = PH_SOFT;
          cnt_d     = '0;
          hard_done = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_SOFT: begin
        cnt_en = 1'b1;
        if (any_req) begin
          phase_d    = PH_HARD;
          cnt_d      = '0;
          hard_start = 1'b1;
        end else if (at_last) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/rst_capture.sv
module rst_capture
  import rst_seq_pkg::*;
#(
  parameter int unsigned        CFG_W       = 8,
  parameter logic [CFG_W-1:0]   CFG_DEFAULT = 'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_start,
  input  logic             hard_done,
  input  src_vec_t         req_eff,
  input  logic             rstconf_n,
  input  logic [CFG_W-1:0] ext_bus_hi,
  output src_vec_t         cause,
  output logic [CFG_W-1:0] cfg_word
);
  src_vec_t         cause_q, cause_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cause_d = req_eff;
    cfg_d   = rstconf_n ? CFG_DEFAULT : ext_bus_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      cfg_q   <= CFG_DEFAULT;
    end else begin
      if (hard_start) cause_q <= cause_d;
      if (hard_done)  cfg_q   <= cfg_d;
    end
  end

  assign cause    = cause_q;
  assign cfg_word = cfg_q;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int unsigned      PHASE_CYCLES = 512,
  parameter int unsigned      SYNC_STAGES  = 2,
  parameter int unsigned      CFG_W        = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT  = 'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_soft,
  input  logic             btn_abort,
  input  logic             pll_lock_a,
  input  logic             pll_lock_b,
  input  logic             chkstop,
  input  logic             chkstop_rst_en,
  input  logic             busmon_tmo,
  input  logic             wdog_exp,
  input  logic             jtag_hreset,
  input  logic             hreset_line_i,
  input  logic             rstconf_n,
  input  logic [CFG_W-1:0] ext_bus_hi,
  output logic             hreset_n_o,
  output logic             hreset_oe,
  output logic             sreset_n_o,
  output logic             sreset_oe,
  output logic [CFG_W-1:0] cfg_word,
  output logic [6:0]       hreset_cause
);
  src_vec_t raw_req, sync_req, req_eff, cause;
  phase_e   phase;
  logic     hard_start, hard_done;

  rst_src_collect u_collect (
    .btn_soft       (btn_soft),
    .btn_abort      (btn_abort),
    .pll_lock_a     (pll_lock_a),
    .pll_lock_b     (pll_lock_b),
    .chkstop        (chkstop),
    .chkstop_rst_en (chkstop_rst_en),
    .busmon_tmo     (busmon_tmo),
    .wdog_exp       (wdog_exp),
    .jtag_hreset    (jtag_hreset),
    .hreset_line_i  (hreset_line_i),
    .raw_req        (raw_req)
  );

  rst_req_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_req),
    .q     (sync_req)
  );

  rst_phase_fsm #(.PHASE_CYCLES(PHASE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (sync_req),
    .phase      (phase),
    .hard_start (hard_start),
    .hard_done  (hard_done),
    .req_eff    (req_eff)
  );

  rst_capture #(.CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_start (hard_start),
    .hard_done  (hard_done),
    .req_eff    (req_eff),
    .rstconf_n  (rstconf_n),
    .ext_bus_hi (ext_bus_hi),
    .cause      (cause),
    .cfg_word   (cfg_word)
  );

  // Open-drain style: data pins only ever pull low; enables gate the pull.
  assign hreset_n_o   = 1'b0;
  assign sreset_n_o   = 1'b0;
  assign hreset_oe    = (phase == PH_HARD);
  assign sreset_oe    = (phase != PH_IDLE);
  assign hreset_cause = cause;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int unsigned PHASE_CYCLES = 512,
  parameter int unsigned CFG_W        = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             btn_soft,
  input logic             btn_abort,
  input logic             hreset_oe,
  input logic             sreset_oe,
  input logic [CFG_W-1:0] cfg_word,
  input logic [6:0]       hreset_cause
);
  localparam int unsigned HW = $clog2(PHASE_CYCLES + 1) + 1;

  logic [HW-1:0] hard_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hard_run_q <= '0;
    else if (hreset_oe) hard_run_q <= hard_run_q + 1'b1;
    else                hard_run_q <= '0;
  end

  AST_HARD_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    hreset_oe |-> (hard_run_q < HW'(PHASE_CYCLES))); // R6
  AST_HARD_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hreset_oe) |-> (hard_run_q == HW'(PHASE_CYCLES))); // R6
  AST_SOFT_COVERS_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    hreset_oe |-> sreset_oe); // R7
  AST_SOFT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hreset_oe) |-> sreset_oe); // R7
  AST_CHORD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_soft && btn_abort && !hreset_oe) |=> ##2 hreset_oe); // R1
  AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(hreset_oe) |-> $stable(hreset_cause)); // R10
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(hreset_oe) |-> $stable(cfg_word)); // R9
endmodule

bind rst_sequencer rst_sequencer_chk #(
  .PHASE_CYCLES (PHASE_CYCLES),
  .CFG_W        (CFG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .btn_soft     (btn_soft),
  .btn_abort    (btn_abort),
  .hreset_oe    (hreset_oe),
  .sreset_oe    (sreset_oe),
  .cfg_word     (cfg_word),
  .hreset_cause (hreset_cause)
);

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
  localparam int unsigned PH  = 512;
  localparam logic [7:0]  DEF = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       btn_soft, btn_abort, pll_lock_a, pll_lock_b;
  logic       chkstop, chkstop_rst_en, busmon_tmo, wdog_exp, jtag_hreset;
  logic       ext_pull, rstconf_n;
  logic [7:0] ext_bus_hi;
  logic       hreset_line;
  logic       hreset_n_o, hreset_oe, sreset_n_o, sreset_oe;
  logic [7:0] cfg_word;
  logic [6:0] hreset_cause;
  logic       pll_sel;
  int         total = 0;
  int         bad   = 0;
  bit         ended = 0;

  always #2 clk = ~clk;

  // wire-AND of the shared hard-reset line
  assign hreset_line = !((hreset_oe && !hreset_n_o) || ext_pull);

  rst_sequencer u_rst_sequencer (
    .clk(clk), .rst_n(rst_n), .btn_soft(btn_soft), .btn_abort(btn_abort),
    .pll_lock_a(pll_lock_a), .pll_lock_b(pll_lock_b), .chkstop(chkstop),
    .chkstop_rst_en(chkstop_rst_en), .busmon_tmo(busmon_tmo), .wdog_exp(wdog_exp),
    .jtag_hreset(jtag_hreset), .hreset_line_i(hreset_line), .rstconf_n(rstconf_n),
    .ext_bus_hi(ext_bus_hi), .hreset_n_o(hreset_n_o), .hreset_oe(hreset_oe),
    .sreset_n_o(sreset_n_o), .sreset_oe(sreset_oe), .cfg_word(cfg_word),
    .hreset_cause(hreset_cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit map of R10: 0 chord,1 pll,2 chkstop,3 busmon,4 wdog,5 jtag,6 line
  task automatic drive_mask(input logic [6:0] m);
    btn_soft    = m[0];
    btn_abort   = m[0];
    pll_lock_a  = !(m[1] && pll_sel);
    pll_lock_b  = !(m[1] && !pll_sel);
    chkstop     = m[2];
    busmon_tmo  = m[3];
    wdog_exp    = m[4];
    jtag_hreset = m[5];
    ext_pull    = m[6];
  endtask

  function automatic logic [6:0] eff_mask(input logic [6:0] m, input logic en);
    logic [6:0] r = m;
    if (!en) r[2] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] exp_cfg(input logic sn, input logic [7:0] bus);
    return sn ? DEF : bus;
  endfunction

  task automatic pulse(input logic [6:0] m);
    drive_mask(m);
    @(negedge clk);
    drive_mask(7'd0);
  endtask

  task automatic wait_rise(output bit seen);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (hreset_oe) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic observe(input logic [6:0] inj_h, input logic [6:0] inj_s,
                         output int hl, output int sl, output bit restarted);
    int sres_miss = 0;
    hl = 0;
    while (hreset_oe === 1'b1 && hl < 2000) begin
      if (!sreset_oe || hreset_n_o !== 1'b0 || sreset_n_o !== 1'b0) sres_miss++;
      drive_mask(hl == 100 ? inj_h : 7'd0);
      hl++;
      @(negedge clk);
    end
    drive_mask(7'd0);
    chk("R7 sreset held and pins low during hard phase", sres_miss, 0);
    sl = 0;
    while (sreset_oe === 1'b1 && hreset_oe === 1'b0 && sl < 2000) begin
      drive_mask(sl == 100 ? inj_s : 7'd0);
      sl++;
      @(negedge clk);
    end
    drive_mask(7'd0);
    restarted = hreset_oe;
  endtask

  task automatic full_run(input logic [6:0] m, input string tag);
    logic [6:0] e;
    bit seen, rs;
    int hl, sl;
    e = eff_mask(m, chkstop_rst_en);
    pulse(m);
    wait_rise(seen);
    if (e == 7'd0) begin
      repeat (8) @(negedge clk);
      chk({tag, " no sequence"}, {30'd0, hreset_oe, sreset_oe}, 0);
    end else begin
      chk({tag, " sequence starts"}, int'(seen), 1);
      if (seen) begin
        observe(7'd0, 7'd0, hl, sl, rs);
        chk("R6 hard length", hl, PH);
        chk("R7 soft length", sl, PH);
        chk("R10 cause", int'(hreset_cause), int'(e));
        chk("R9 cfg", int'(cfg_word), int'(exp_cfg(rstconf_n, ext_bus_hi)));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen, rs;
    int hl, sl;
    void'($urandom(32'h1234_abcd));
    pll_sel = 1'b1;
    drive_mask(7'd0);
    chkstop_rst_en = 1'b0;
    rstconf_n = 1'b1;
    ext_bus_hi = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset oe", {30'd0, hreset_oe, sreset_oe}, 0);
    chk("R11 reset cause", int'(hreset_cause), 0);
    chk("R11 reset cfg", int'(cfg_word), int'(DEF));
    chk("R6 pin low", int'(hreset_n_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 single buttons ignored, chord triggers
    btn_soft = 1'b1; @(negedge clk); btn_soft = 1'b0;
    repeat (8) @(negedge clk);
    chk("R1 soft button alone", {30'd0, hreset_oe, sreset_oe}, 0);
    btn_abort = 1'b1; @(negedge clk); btn_abort = 1'b0;
    repeat (8) @(negedge clk);
    chk("R1 abort button alone", {30'd0, hreset_oe, sreset_oe}, 0);
    full_run(7'b0000001, "R1 chord");
    // R2 both PLLs
    pll_sel = 1'b1; full_run(7'b0000010, "R2 pll a");
    pll_sel = 1'b0; full_run(7'b0000010, "R2 pll b");
    // R3 check-stop gating
    chkstop_rst_en = 1'b0; full_run(7'b0000100, "R3 chkstop disabled");
    chk("R3 cause untouched", int'(hreset_cause), 7'b0000010);
    chkstop_rst_en = 1'b1; full_run(7'b0000100, "R3 chkstop enabled");
    // R4 other internal sources, R9 external config
    rstconf_n = 1'b0; ext_bus_hi = 8'hC3;
    full_run(7'b0001000, "R4 busmon");
    rstconf_n = 1'b1;
    full_run(7'b0010000, "R4 wdog");
    full_run(7'b0100000, "R4 jtag");
    // R5 external line
    full_run(7'b1000000, "R5 line");

    // R8 hard-phase request ignored, soft-phase request restarts
    pulse(7'b0100000);
    wait_rise(seen);
    chk("R8 start", int'(seen), 1);
    observe(7'b0010000, 7'b0001000, hl, sl, rs);
    chk("R8 hard length kept", hl, PH);
    chk("R8 soft restart", int'(rs), 1);
    chk("R8 cause from restart", int'(hreset_cause), 7'b0001000);
    observe(7'd0, 7'd0, hl, sl, rs);
    chk("R8 second hard length", hl, PH);
    chk("R8 second soft length", sl, PH);
    // R5 line pulled during soft phase only is masked
    pulse(7'b0100000);
    wait_rise(seen);
    observe(7'd0, 7'b1000000, hl, sl, rs);
    chk("R5 line masked in soft phase", int'(rs), 0);
    chk("R5 soft length", sl, PH);
    chk("R10 cause kept idle", int'(hreset_cause), 7'b0100000);

    // random mixes
    for (int it = 0; it < 30; it++) begin
      logic [6:0] m;
      m = 7'($urandom);
      pll_sel = 1'($urandom);
      chkstop_rst_en = 1'($urandom);
      rstconf_n = 1'($urandom);
      ext_bus_hi = 8'($urandom);
      full_run(m, "R10 random mix");
    end

    // R10 cleared only by power-on reset
    pulse(7'b0000001);
    wait_rise(seen);
    observe(7'd0, 7'd0, hl, sl, rs);
    repeat (20) @(negedge clk);
    chk("R10 cause kept", int'(hreset_cause), 7'b0000001);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 cleared by reset", int'(hreset_cause), 0);
    chk("R11 cfg after reset", int'(cfg_word), int'(DEF));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule